// File: doc/BRIEF.md
# Watchdog Event Reset Router

This block sits between a watchdog timer and the reset and interrupt inputs of one processor core. When the watchdog fires, the block records the event in a sticky status bit. It then converts the event into the action chosen by software. The action is one of: nothing, a local reset pulse, a non-maskable interrupt pulse, a device-wide reset request, or an interrupt followed after a programmable wait by a local reset. The wait is counted in ticks of a divided system clock, which reaches the block as a clock-enable input.

Software reaches the block through one 32-bit control word with a single-cycle write strobe and a combinational read path. A lock bit freezes the configuration fields. Once the lock is set, only the reset of the block releases it, and that reset comes from the watchdog timer's reset.

Top module: `wdt_reset_router`

## Requirements
- R1: After reset the control word reads 0x0000_0080: action code 000, wait code 100, lock 0, status 0. All three outputs are low.
- R2: Control word layout. Bit 0 is the lock. Bits 3:1 are the action code. Bit 4 is the status and is read-only. Bits 7:5 are the wait code. Bit 9 is a write-only clear strobe. Bits 8, 9 and 31:10 read as zero.
- R3: Action codes 000, 001, 110 and 111 turn an event into no output pulse at all.
- R4: With action code 010, an event gives a one-cycle `lrst_o` pulse in the cycle after the event is sampled.
- R5: With action code 011, an event gives a one-cycle `nmi_o` pulse in the cycle after the event is sampled.
- R6: With action code 101, an event gives a one-cycle `devrst_o` pulse in the cycle after the event is sampled.
- R7: With action code 100, an event gives an `nmi_o` pulse at once. `lrst_o` then pulses exactly 2^(BASE_LOG2 + wait code) `tick_en` cycles later. Ticks are counted from the cycle after the event. The action and the wait are taken from the values held when the event is sampled.
- R8: While that wait is running, further events produce no output pulse, although they still set the status bit.
- R9: Status becomes 1 when an event is sampled. A write with bit 9 at 1 clears it. A write with bit 9 at 0 leaves it unchanged. When an event and a clearing write fall in the same cycle, status ends at 1.
- R10: While the lock is 1, writes leave the lock, the action code and the wait code unchanged, but the bit-9 clear still acts. Only reset releases the lock.
- R11: With EDGE_DETECT = 1, an event is a rising edge of `wd_event`. An input held high produces exactly one event.
- R12: At most one of the three outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset from the timer reset; it is the only thing that releases the lock |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Data for a control word write |
| rd_data | output | 32 | Current control word value |
| wd_event | input | 1 | Watchdog timer event |
| tick_en | input | 1 | One-cycle enable from the divided system clock, used to time the wait |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| lrst_o | output | 1 | Local reset pulse |
| devrst_o | output | 1 | Device reset request pulse |

## Verification
The bench builds the block with BASE_LOG2 = 2, so the eight wait codes span 4 to 512 ticks instead of 256 to 32768. Every wait code can therefore be run to completion, including the longest, and events can be injected in the middle of a wait. The bench keeps EDGE_DETECT = 1, so a held-high watchdog line is exercised. The tick enable is driven both on every cycle and at sparser rates, so the wait is checked against ticks rather than clock cycles.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned DLY_W    = 3;
   localparam int unsigned LOCK_B   = 0;
   localparam int unsigned MODE_LSB = 1;
   localparam int unsigned STAT_B   = 4;
   localparam int unsigned DLY_LSB  = 5;
   localparam int unsigned CLR_B    = 9;

   typedef enum logic [2:0] {
      ACT_NONE     = 3'b000,
      ACT_RSV1     = 3'b001,
      ACT_LRST     = 3'b010,
      ACT_NMI      = 3'b011,
      ACT_NMI_LRST = 3'b100,
      ACT_DEV      = 3'b101,
      ACT_RSV6     = 3'b110,
      ACT_RSV7     = 3'b111
   } action_e;

   typedef struct packed {
      logic [DLY_W-1:0] dly;
      action_e          act;
      logic             lock;
   } cfg_t;

   localparam logic [DLY_W-1:0] DLY_RST = 3'b100;
endpackage

// File: rtl/wrr_cfg_reg.sv
module wrr_cfg_reg
   import wrr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             evt,
   output cfg_t             cfg,
   output logic             stat
);
   logic clr_req;
   assign clr_req = wr_en & wr_data[CLR_B];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '{dly: DLY_RST, act: ACT_NONE, lock: 1'b0};
      end else if (wr_en && !cfg.lock) begin
         cfg <= '{dly:  wr_data[DLY_LSB +: DLY_W],
                  act:  action_e'(wr_data[MODE_LSB +: 3]),
                  lock: wr_data[LOCK_B]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stat <= 1'b0;
      else if (evt)     stat <= 1'b1;
      else if (clr_req) stat <= 1'b0;
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data[REG_W-1:CLR_B+1], wr_data[8], wr_data[STAT_B]};

   p_lock_freezes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg.lock) |-> $stable(cfg));
   p_evt_sets_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> stat);
   p_stat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat && !clr_req) |=> stat);
endmodule

// File: rtl/wrr_evt_detect.sv
module wrr_evt_detect #(
   parameter int unsigned EDGE_DETECT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wd_event,
   output logic evt
);
   generate
      if (EDGE_DETECT != 0) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= wd_event;
         end
         assign evt = wd_event & ~prev_q;

         p_single_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
            evt |=> !evt);
      end else begin : g_level
         assign evt = wd_event;
      end
   endgenerate
endmodule

// File: rtl/wrr_seq.sv
module wrr_seq
   import wrr_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 8,
   parameter int unsigned CNT_W     = BASE_LOG2 + (1 << DLY_W)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic tick_en,
   input  cfg_t cfg,
   output logic nmi_o,
   output logic lrst_o,
   output logic devrst_o
);
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   assign load_val = {{(CNT_W-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(cfg.dly));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         cnt_q    <= '0;
         nmi_o    <= 1'b0;
         lrst_o   <= 1'b0;
         devrst_o <= 1'b0;
      end else begin
         nmi_o    <= 1'b0;
         lrst_o   <= 1'b0;
         devrst_o <= 1'b0;
         if (busy_q && tick_en) begin
            if (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
               lrst_o <= 1'b1;
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         if (evt && !busy_q) begin
            unique case (cfg.act)
               ACT_LRST: lrst_o <= 1'b1;
               ACT_NMI:  nmi_o  <= 1'b1;
               ACT_NMI_LRST: begin
                  nmi_o  <= 1'b1;
                  busy_q <= 1'b1;
                  cnt_q  <= load_val;
               end
               ACT_DEV:  devrst_o <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   p_one_output_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nmi_o, lrst_o, devrst_o}));
   p_wait_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> (!nmi_o && !devrst_o));
   p_wait_armed_by_nmi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> nmi_o);
   p_cnt_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q != '0));
   p_idle_codes_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !busy_q && cfg.act inside {ACT_NONE, ACT_RSV1, ACT_RSV6, ACT_RSV7})
      |=> (!nmi_o && !lrst_o && !devrst_o));
endmodule

// File: rtl/wdt_reset_router.sv
module wdt_reset_router
   import wrr_pkg::*;
#(
   parameter int unsigned BASE_LOG2   = 8,
   parameter int unsigned EDGE_DETECT = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   input  logic        wd_event,
   input  logic        tick_en,
   output logic        nmi_o,
   output logic        lrst_o,
   output logic        devrst_o
);
   localparam int unsigned CNT_W = BASE_LOG2 + (1 << DLY_W);

   generate
      if (BASE_LOG2 < 1 || BASE_LOG2 > 24) begin : g_bad_base
         $error("wdt_reset_router: BASE_LOG2 out of range");
      end
      if (EDGE_DETECT > 1) begin : g_bad_edge
         $error("wdt_reset_router: EDGE_DETECT must be 0 or 1");
      end
   endgenerate

   cfg_t cfg;
   logic stat;
   logic evt;

   wrr_evt_detect #(.EDGE_DETECT(EDGE_DETECT)) u_evt (
      .clk(clk), .rst_n(rst_n), .wd_event(wd_event), .evt(evt)
   );

   wrr_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .evt(evt), .cfg(cfg), .stat(stat)
   );

   wrr_seq #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .evt(evt), .tick_en(tick_en), .cfg(cfg),
      .nmi_o(nmi_o), .lrst_o(lrst_o), .devrst_o(devrst_o)
   );

   always_comb begin
      rd_data                      = '0;
      rd_data[LOCK_B]              = cfg.lock;
      rd_data[MODE_LSB +: 3]       = cfg.act;
      rd_data[STAT_B]              = stat;
      rd_data[DLY_LSB +: DLY_W]    = cfg.dly;
   end

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[31:9] == '0) && !rd_data[8]);
endmodule

// File: tb/wdt_reset_router_bench.sv
module wdt_reset_router_bench;
   localparam int BASE = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        wd_event = 1'b0;
   logic        tick_en = 1'b1;
   logic        nmi_o, lrst_o, devrst_o;

   always #2.5 clk = ~clk;

   wdt_reset_router #(.BASE_LOG2(BASE), .EDGE_DETECT(1)) u_wdt_reset_router (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .wd_event(wd_event), .tick_en(tick_en),
      .nmi_o(nmi_o), .lrst_o(lrst_o), .devrst_o(devrst_o)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc_n = 0;
   int    tick_div = 1;
   string phase = "R1";

   // behavioural reference model
   int m_lock, m_mode, m_dly, m_stat, m_busy, m_cnt, m_prev;
   int e_nmi, e_lrst, e_dev;

   always @(posedge clk) begin
      int ev, was;
      if (!rst_n) begin
         m_lock = 0; m_mode = 0; m_dly = 4; m_stat = 0; m_busy = 0;
         m_cnt = 0; m_prev = 0; e_nmi = 0; e_lrst = 0; e_dev = 0;
      end else begin
         e_nmi = 0; e_lrst = 0; e_dev = 0;
         ev = (wd_event && m_prev == 0) ? 1 : 0;
         m_prev = wd_event ? 1 : 0;
         was = m_busy;
         if (was != 0 && tick_en) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin e_lrst = 1; m_busy = 0; end
         end
         if (ev != 0 && was == 0) begin
            case (m_mode)
               2: e_lrst = 1;
               3: e_nmi = 1;
               4: begin e_nmi = 1; m_busy = 1; m_cnt = 1 << (BASE + m_dly); end
               5: e_dev = 1;
               default: ;
            endcase
         end
         if (wr_en && wr_data[9]) m_stat = 0;
         if (ev != 0) m_stat = 1;
         if (wr_en && m_lock == 0) begin
            m_lock = int'(wr_data[0]);
            m_mode = int'(wr_data[3:1]);
            m_dly  = int'(wr_data[7:5]);
         end
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] model_word();
      return {22'b0, 1'b0, 1'b0, m_dly[2:0], m_stat[0], m_mode[2:0], m_lock[0]};
   endfunction

   task automatic cyc();
      @(negedge clk);
      if (rst_n) begin
         chk(phase, "rd_data", rd_data, model_word());
         chk(phase, "nmi_o", {31'b0, nmi_o}, e_nmi);
         chk(phase, "lrst_o", {31'b0, lrst_o}, e_lrst);
         chk(phase, "devrst_o", {31'b0, devrst_o}, e_dev);
         chk("R12", "one-hot outputs", {31'b0, $onehot0({nmi_o, lrst_o, devrst_o})}, 1);
      end
      cyc_n++;
      tick_en = (cyc_n % tick_div) == 0;
   endtask

   function automatic logic [31:0] cw(input logic lk, input logic [2:0] md,
                                      input logic [2:0] dl, input logic clr);
      return {22'b0, clr, 1'b0, dl, 1'b0, md, lk};
   endfunction

   task automatic wr(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic evt_pulse();
      wd_event = 1'b1; cyc(); wd_event = 1'b0; cyc();
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
   endtask

   task automatic wait_lrst(input int limit, output int n);
      n = 0;
      while (!lrst_o && n < limit) begin cyc(); n++; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=fewer", cyc_n);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int n;
      do_reset();
      phase = "R1";
      chk("R1", "reset word", rd_data, 32'h0000_0080);
      chk("R1", "reset outputs", {29'b0, nmi_o, lrst_o, devrst_o}, 0);

      phase = "R2";
      wr(32'hFFFF_FFFE);
      chk("R2", "layout readback", rd_data, 32'h0000_00EE);
      wr(cw(0, 3'b000, 3'b010, 0));
      chk("R2", "fields readback", rd_data, 32'h0000_0040);

      phase = "R3";
      foreach (n_cmp_modes[i]) ;
      for (int m = 0; m < 8; m++) begin
         if (m == 0 || m == 1 || m == 6 || m == 7) begin
            wr(cw(0, m[2:0], 3'b000, 1));
            evt_pulse(); cyc();
         end
      end
      chk("R3", "status after silent codes", {31'b0, rd_data[4]}, 1);

      phase = "R4";
      wr(cw(0, 3'b010, 3'b000, 1));
      wd_event = 1'b1; cyc(); wd_event = 1'b0;
      chk("R4", "local reset pulse", {31'b0, lrst_o}, 1);
      cyc();
      chk("R4", "pulse is one cycle", {31'b0, lrst_o}, 0);

      phase = "R5";
      wr(cw(0, 3'b011, 3'b000, 1));
      wd_event = 1'b1; cyc(); wd_event = 1'b0;
      chk("R5", "nmi pulse", {31'b0, nmi_o}, 1);
      cyc();

      phase = "R6";
      wr(cw(0, 3'b101, 3'b000, 1));
      wd_event = 1'b1; cyc(); wd_event = 1'b0;
      chk("R6", "device reset pulse", {31'b0, devrst_o}, 1);
      cyc();

      phase = "R7";
      wr(cw(0, 3'b100, 3'b000, 1));
      wd_event = 1'b1; cyc(); wd_event = 1'b0;
      chk("R7", "nmi first", {31'b0, nmi_o}, 1);
      wait_lrst(5000, n);
      chk("R7", "wait code 0 cycles", n, 4);
      cyc();
      for (int d = 1; d < 8; d++) begin
         tick_div = (d % 3) + 1;
         wr(cw(0, 3'b100, d[2:0], 1));
         evt_pulse();
         wait_lrst(20000, n);
         cyc();
      end
      tick_div = 1;
      wr(cw(0, 3'b100, 3'b111, 1));
      wd_event = 1'b1; cyc(); wd_event = 1'b0;
      wait_lrst(5000, n);
      chk("R7", "longest wait cycles", n, 512);
      cyc();

      phase = "R8";
      wr(cw(0, 3'b100, 3'b011, 1));
      evt_pulse();
      wr(cw(0, 3'b100, 3'b011, 1));
      repeat (5) cyc();
      evt_pulse();
      chk("R8", "status set during wait", {31'b0, rd_data[4]}, 1);
      wr(cw(0, 3'b011, 3'b011, 1));
      evt_pulse();
      wait_lrst(5000, n);
      cyc();
      repeat (3) cyc();

      phase = "R9";
      wr(cw(0, 3'b000, 3'b100, 1));
      evt_pulse();
      chk("R9", "status set", {31'b0, rd_data[4]}, 1);
      wr(cw(0, 3'b000, 3'b100, 0));
      chk("R9", "zero clear keeps status", {31'b0, rd_data[4]}, 1);
      wr(cw(0, 3'b000, 3'b100, 1));
      chk("R9", "clear drops status", {31'b0, rd_data[4]}, 0);
      wd_event = 1'b1; wr(cw(0, 3'b000, 3'b100, 1)); wd_event = 1'b0; cyc();
      chk("R9", "event beats clear", {31'b0, rd_data[4]}, 1);

      phase = "R11";
      wr(cw(0, 3'b011, 3'b100, 1));
      n = 0;
      wd_event = 1'b1;
      repeat (10) begin cyc(); if (nmi_o) n++; end
      wd_event = 1'b0; cyc();
      chk("R11", "held input gives one pulse", n, 1);

      phase = "R10";
      wr(cw(1, 3'b010, 3'b001, 1));
      wr(cw(0, 3'b011, 3'b110, 0));
      chk("R10", "locked fields", rd_data, 32'h0000_0025);
      wd_event = 1'b1; cyc(); wd_event = 1'b0;
      chk("R10", "locked code still acts", {31'b0, lrst_o}, 1);
      cyc();
      wr(cw(0, 3'b011, 3'b110, 1));
      chk("R10", "clear works while locked", rd_data, 32'h0000_0025);
      do_reset();
      chk("R10", "reset releases lock", rd_data, 32'h0000_0080);
      wr(cw(0, 3'b101, 3'b000, 0));
      chk("R10", "writable after reset", rd_data, 32'h0000_000A);

      repeat (3) cyc();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   int n_cmp_modes[1];
endmodule